// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block collects level-sensitive interrupt sources into groups of eight and gives each group one output line toward a parent interrupt controller. All groups share one 32-bit word of per-source enable bits, and group `g` holds the byte lane that starts at bit `8*g`. A group's output is high while any enabled source in its lane is high.

Software changes enables only through two write-one registers. One register turns on the sources whose bits are written as 1. The other turns them off. Zero bits leave the enables as they are, so handlers for different sources never need a read-modify-write. A status register returns each raw source ANDed with its enable bit. The parent controller, or the software behind it, uses that register to find which source in a group is active. Choosing a winner among active sources is left to that software.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset every enable bit is 0, every `irq_out` bit is 0, and reads of offsets 0x0 and 0xC return 0 whatever the sources are.
- R2: A write to offset 0x0 sets each enable bit whose written bit is 1. Enable bits whose written bit is 0 keep their value. The change is visible from the cycle after the write.
- R3: A write to offset 0x4 clears each enable bit whose written bit is 1. Enable bits whose written bit is 0 keep their value.
- R4: Reads of offset 0x0 and of offset 0x4 both return the current 32-bit enable word, with bit i belonging to source i.
- R5: A read of offset 0xC returns `irq_src & enable`, bit for bit. Source i sits at bit i, so group g owns bits 8g to 8g+7.
- R6: `irq_out[g]` is registered. After a clock edge it equals the OR of bits 8g to 8g+7 of `irq_src & enable`, using the source and enable values held just before that edge.
- R7: Writes to offset 0x8 or 0xC do not change any enable bit. A read of offset 0x8 returns 0.
- R8: Sources are levels. An enabled source held high keeps its group output high for as long as it is held. The output drops one cycle after the last enabled source in the lane falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32 | Level interrupt sources, source i at bit i |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_out | output | 4 | One registered output per group |

## Verification
Two events can fall in the same cycle: an enable write and a change on a source in the same lane. The case to watch is a clear of a source's enable in the very cycle that source rises. The bench sets this up with directed cases and also lets random writes to set and clear land together with random source changes. The expected output is computed in the bench from the source value and the enable value held before the edge, and the write is applied to the model only after that. So the group output must show exactly one cycle high and then drop. For the reverse case, a set that arrives together with the rise, the output must rise one cycle later than it would for an enable set earlier.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int OFF_EN_SET = 'h0;
   localparam int OFF_EN_CLR = 'h4;
   localparam int OFF_RSVD   = 'h8;
   localparam int OFF_STATUS = 'hC;
endpackage

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_stb,
   input  logic             clr_stb,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] en_q
);
   logic [WIDTH-1:0] set_bits;
   logic [WIDTH-1:0] clr_bits;
   logic [WIDTH-1:0] en_d;

   always_comb begin
      set_bits = set_stb ? mask : '0;
      clr_bits = clr_stb ? mask : '0;
      en_d     = (en_q | set_bits) & ~clr_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d;
   end

   // R1
   reset_clears_chk: assert property (@(posedge clk) !rst_n |=> en_q == '0);
   // R2
   set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> (en_q & $past(mask)) == $past(mask));
   // R3
   clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> (en_q & $past(mask)) == '0);
   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_stb && !clr_stb) |=> $stable(en_q));
endmodule

// File: rtl/irqc_lane_or.sv
module irqc_lane_or #(
   parameter int GW      = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [GW-1:0] lane,
   output logic          any_o
);
   logic any_c;
   assign any_c = |lane;

   generate
      if (REG_OUT) begin : g_reg
         logic any_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) any_q <= 1'b0;
            else        any_q <= any_c;
         end
         assign any_o = any_q;
      end else begin : g_comb
         assign any_o = any_c;
      end
   endgenerate
endmodule

// File: rtl/irqc_reg_port.sv
module irqc_reg_port
   import irqc_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              we,
   input  logic [DATA_W-1:0] en_i,
   input  logic [DATA_W-1:0] status_i,
   output logic [DATA_W-1:0] rdata,
   output logic              set_stb,
   output logic              clr_stb,
   output logic [DATA_W-1:0] mask
);
   logic hit_set, hit_clr, hit_stat;

   always_comb begin
      hit_set  = (addr == ADDR_W'(OFF_EN_SET));
      hit_clr  = (addr == ADDR_W'(OFF_EN_CLR));
      hit_stat = (addr == ADDR_W'(OFF_STATUS));
      set_stb  = we && hit_set;
      clr_stb  = we && hit_clr;
      mask     = wdata;
      if (hit_set || hit_clr) rdata = en_i;
      else if (hit_stat)      rdata = status_i;
      else                    rdata = '0;
   end
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner #(
   parameter int NUM_GROUPS = 4,
   parameter int GROUP_W    = 8,
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 32,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [DATA_W-1:0]     irq_src,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   input  logic                  reg_we,
   output logic [DATA_W-1:0]     reg_rdata,
   output logic [NUM_GROUPS-1:0] irq_out
);
   localparam int SRC_W = NUM_GROUPS * GROUP_W;

   generate
      if (SRC_W != DATA_W) begin : g_bad_width
         $error("group lanes must exactly fill the register word");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("address too narrow for the register offsets");
      end
   endgenerate

   logic [DATA_W-1:0] en_q;
   logic [DATA_W-1:0] status;
   logic [DATA_W-1:0] mask;
   logic              set_stb, clr_stb;

   assign status = irq_src & en_q;

   irqc_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
      .en_i(en_q), .status_i(status), .rdata(reg_rdata),
      .set_stb(set_stb), .clr_stb(clr_stb), .mask(mask)
   );

   irqc_enable_bank #(.WIDTH(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .clr_stb(clr_stb),
      .mask(mask), .en_q(en_q)
   );

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lane
         irqc_lane_or #(.GW(GROUP_W), .REG_OUT(REG_OUT)) u_or (
            .clk(clk), .rst_n(rst_n),
            .lane(status[g*GROUP_W +: GROUP_W]),
            .any_o(irq_out[g])
         );
         if (REG_OUT) begin : g_chk
            // R6
            lane_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
               1'b1 |=> irq_out[g] ==
                  ($past(irq_src[g*GROUP_W +: GROUP_W] & en_q[g*GROUP_W +: GROUP_W]) != '0));
         end
      end
   endgenerate
endmodule

// File: tb/tb_irq_group_combiner.sv
module tb_irq_group_combiner;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_src = '0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_rdata;
   logic [3:0]  irq_out;

   int checks = 0;
   int failures = 0;
   logic [31:0] men = '0;
   logic [3:0]  exp_out = '0;

   always #2.5 clk = ~clk;

   irq_group_combiner dut (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
      .irq_out(irq_out)
   );

   function automatic logic [3:0] lanes_or(input logic [31:0] w);
      logic [3:0] r;
      for (int g = 0; g < 4; g++) r[g] = |w[g*8 +: 8];
      return r;
   endfunction

   function automatic logic [31:0] read_model(input logic [3:0] a, input logic [31:0] s);
      if (a == 4'h0 || a == 4'h4) return men;
      if (a == 4'hC) return s & men;
      return '0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Called at a negedge; drives, passes one posedge, checks at the next negedge.
   task automatic step(input logic [3:0] a, input logic [31:0] d, input logic w,
                       input logic [31:0] s, input string req);
      reg_addr = a; reg_wdata = d; reg_we = w; irq_src = s;
      @(posedge clk);
      exp_out = lanes_or(s & men);
      if (w && a == 4'h0) men = men | d;
      else if (w && a == 4'h4) men = men & ~d;
      @(negedge clk);
      chk(req, {28'd0, irq_out}, {28'd0, exp_out});
   endtask

   task automatic rd(input logic [3:0] a, input string req);
      reg_addr = a; reg_we = 1'b0;
      #0.5;
      chk(req, reg_rdata, read_model(a, irq_src));
   endtask

   initial begin
      #200000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'd4711);
      irq_src = 32'hFFFF_FFFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state, even with all sources high
      chk("R1 out", {28'd0, irq_out}, 32'd0);
      rd(4'h0, "R1 en");
      rd(4'hC, "R1 status");
      rst_n = 1'b1;
      @(negedge clk);
      // R2 set lane0 bit3 and lane2 bit0
      step(4'h0, 32'h0001_0008, 1'b1, 32'h0, "R2 set");
      rd(4'h0, "R2 readback");
      rd(4'h4, "R4 alias");
      step(4'h0, 32'h0, 1'b0, 32'h0001_0008, "R6 drive");
      step(4'h0, 32'h0, 1'b0, 32'h0001_0008, "R6 both lanes");
      // R5 status and masked sources
      irq_src = 32'hFFFF_FFFF;
      rd(4'hC, "R5 status");
      // R8 hold then release
      step(4'h0, 32'h0, 1'b0, 32'h0000_0008, "R8 hold");
      step(4'h0, 32'h0, 1'b0, 32'h0000_0008, "R8 held");
      step(4'h0, 32'h0, 1'b0, 32'h0, "R8 release");
      step(4'h0, 32'h0, 1'b0, 32'h0, "R8 low");
      // R3 clear only lane2 bit0, lane0 bit3 kept
      step(4'h4, 32'h0001_0000, 1'b1, 32'h0, "R3 clear");
      rd(4'h0, "R3 readback");
      // clear on the same cycle a source in its lane rises
      step(4'h4, 32'h0000_0008, 1'b1, 32'h0000_0008, "R6 clear+rise");
      step(4'h0, 32'h0, 1'b0, 32'h0000_0008, "R6 after clear");
      // set on the same cycle as a rise
      step(4'h0, 32'h8000_0000, 1'b1, 32'h8000_0000, "R6 set+rise");
      step(4'h0, 32'h0, 1'b0, 32'h8000_0000, "R6 after set");
      // R7 writes to reserved and status offsets ignored
      step(4'h8, 32'hFFFF_FFFF, 1'b1, 32'h0, "R7 wr 8");
      step(4'hC, 32'hFFFF_FFFF, 1'b1, 32'h0, "R7 wr C");
      rd(4'h0, "R7 enables unchanged");
      rd(4'h8, "R7 read 8");
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [3:0] a;
         a = 4'($urandom_range(0, 3) * 4);
         step(a, $urandom, 1'($urandom_range(0, 1)),
              $urandom & $urandom, "R6 random");
         if (i % 4 == 0) rd(4'($urandom_range(0, 3) * 4), "R5 random read");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule